// File: doc/BRIEF.md
# Cell Bus Unit Port

This block attaches one unit to a shared 32-bit cell bus, where each frame lasts a fixed number of clock cycles. The arbiter marks the first cycle of every frame with an active-low frame sync. That cycle is the request cycle: each unit that wants the bus drives only its own pair of data bits. The arbiter names the next transmitter in the last cycle of the frame. The port reads its identity from five active-low strap pins. It raises its request pair when a cell is pending. When it sees a grant naming itself, it drives the cell words in the frame that follows.

On the receive side, the port watches every frame that follows a valid grant. It inspects the first cell word, which carries a destination in bits [4:0] and a multicast/broadcast flag in bit 5. If the cell is for this unit, the port passes the words of the cell to the receive FIFO. For unicast cells it pulses an active-low acknowledge in the next request cycle. An inhibit input stops all driving but leaves reception working. A receive-full input blocks FIFO writes but does not hold back the acknowledge.

Top module: `cell_bus_port`

## Requirements
- R1: The unit address is the bitwise inverse of `unit_addr_n`. With address `a`, the request drives bits `2*(a mod 16)+1` and `2*(a mod 16)` of `bus_out`, with the same mask on `bus_oe`. Strap 5'b10000 (address 15) gives 32'hC000_0000, strap 5'b01010 (address 21) gives 32'h0000_0C00, and strap 5'b11111 (address 0) gives 32'h0000_0003.
- R2: In the request cycle (`frame_sync_n` low), the port drives its request pair only when `tx_pending` is high and `inhibit` is low. Otherwise `bus_oe` is zero in that cycle.
- R3: A grant arrives in the last frame cycle (cycle 15) as bit 5 set with bits [4:0] equal to the unit address. If the port requested in that frame's request cycle, then in cycles 1 to 14 of the next frame it drives `bus_out = tx_word`, sets `bus_oe` to all ones, and pulses `tx_rd`.
- R4: The port does not request in the request cycle of a frame in which it transmits.
- R5: Outside its request pair and its own transmit cycles, `bus_oe` is zero. This includes cycle 15 and every cycle before the first frame sync.
- R6: A frame carries a cell when the previous frame's cycle 15 held a valid grant. The port accepts that cell when word 1 has bit 5 set or bits [4:0] equal to the unit address. It then asserts `rx_we` in cycles 1 to 14, with `rx_data` equal to `bus_in`. In all other cases it never asserts `rx_we`.
- R7: After accepting a unicast cell, the port drives `ack_n` low for exactly the next request cycle. `ack_n` is high in every other cycle.
- R8: A cell accepted through the multicast/broadcast flag is never acknowledged.
- R9: `rx_full` high suppresses `rx_we` but does not suppress the acknowledge of a unicast cell.
- R10: While `inhibit` is high, the port makes no request, no transmission and no acknowledge. It still asserts `rx_we` for cells addressed to it.
- R11: While `rst_n` is low, and after reset before any frame sync, `ack_n` is 1 and `bus_oe`, `tx_rd` and `rx_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_addr_n | input | 5 | Active-low unit address straps |
| inhibit | input | 1 | High blocks request, transmit and acknowledge |
| frame_sync_n | input | 1 | Low in the request cycle of each frame |
| bus_in | input | 32 | Value seen on the shared data bus |
| bus_out | output | 32 | Value this unit drives onto the bus |
| bus_oe | output | 32 | Per-bit drive enable for `bus_out` |
| tx_pending | input | 1 | A cell is waiting to be sent |
| tx_word | input | 32 | Current word of the outgoing cell |
| tx_rd | output | 1 | Advances the outgoing cell word |
| rx_full | input | 1 | Receive FIFO cannot take a word |
| rx_we | output | 1 | Write strobe into the receive FIFO |
| rx_data | output | 32 | Word offered to the receive FIFO |
| ack_n | output | 1 | Active-low acknowledge of a unicast cell |

## Verification
The request cycle is shared by two functions: the request pair for a new cell, and the acknowledge owed from the previous frame's unicast cell. To provoke this, the bench gives the unit a pending cell while it still owes an acknowledge. In that one cycle it expects both the exact request mask on `bus_oe` and `ack_n` low. It then repeats the frame with `inhibit` high, where both must vanish while the incoming cell is still written.

// File: rtl/cell_bus_port.sv
module cell_bus_port #(
  parameter int FRAME_LEN = 16,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] unit_addr_n,
  input  logic          inhibit,
  input  logic          frame_sync_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  input  logic          tx_pending,
  input  logic [DW-1:0] tx_word,
  output logic          tx_rd,
  input  logic          rx_full,
  output logic          rx_we,
  output logic [DW-1:0] rx_data,
  output logic          ack_n
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam int LAST_WORD = FRAME_LEN - 2;
  localparam int GRANT_AT = FRAME_LEN - 1;
  localparam int FLAG = AW;

  logic [AW-1:0] own;
  logic [CW-1:0] phase_q, cur;
  logic          locked, req_cyc, body, first, grant_cyc;
  logic          req_q, tx_frame, busy_q, hit_q, ack_q;
  logic          req_drive, tx_act, hit_now;
  logic [DW-1:0] pair_mask;

  assign own       = ~unit_addr_n;
  assign req_cyc   = ~frame_sync_n;
  assign cur       = req_cyc ? '0 : phase_q;
  assign body      = locked && !req_cyc && cur != '0 && cur <= CW'(LAST_WORD);
  assign first     = locked && !req_cyc && cur == CW'(1);
  assign grant_cyc = locked && !req_cyc && cur == CW'(GRANT_AT);
  assign pair_mask = DW'(3) << {own[AW-2:0], 1'b0};

  assign req_drive = req_cyc && tx_pending && !inhibit && !tx_frame;
  assign tx_act    = tx_frame && body && !inhibit;
  assign hit_now   = busy_q && (bus_in[FLAG] || bus_in[AW-1:0] == own);

  assign bus_out = tx_act ? tx_word : (req_drive ? pair_mask : '0);
  assign bus_oe  = tx_act ? '1 : (req_drive ? pair_mask : '0);
  assign tx_rd   = tx_act;
  assign rx_data = bus_in;
  assign rx_we   = body && !rx_full && (first ? hit_now : hit_q);
  assign ack_n   = !(req_cyc && ack_q && !inhibit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      phase_q  <= '0;
      req_q    <= 1'b0;
      tx_frame <= 1'b0;
      busy_q   <= 1'b0;
      hit_q    <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      phase_q <= cur + CW'(1);
      if (req_cyc) begin
        locked <= 1'b1;
        req_q  <= req_drive;
        ack_q  <= 1'b0;
      end
      if (first) begin
        hit_q <= hit_now;
        if (busy_q && !bus_in[FLAG] && bus_in[AW-1:0] == own) ack_q <= 1'b1;
      end
      if (grant_cyc) begin
        busy_q   <= bus_in[FLAG];
        tx_frame <= bus_in[FLAG] && bus_in[AW-1:0] == own && req_q;
        hit_q    <= 1'b0;
      end
    end
  end
endmodule

module cell_bus_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inhibit,
  input logic          frame_sync_n,
  input logic [DW-1:0] bus_out,
  input logic [DW-1:0] bus_oe,
  input logic [DW-1:0] tx_word,
  input logic          tx_rd,
  input logic          rx_full,
  input logic          rx_we,
  input logic          ack_n
);
  p_ack_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !frame_sync_n);
  p_ack_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);
  p_pair_only_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bus_oe) == 2) |-> !frame_sync_n);
  p_oe_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == '0 || bus_oe == '1 || $countones(bus_oe) == 2);
  p_tx_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd |-> (bus_oe == '1 && bus_out == tx_word));
  p_tx_not_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd |-> frame_sync_n);
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_we);
  p_inhibit_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (bus_oe == '0 && ack_n && !tx_rd));
endmodule

bind cell_bus_port cell_bus_port_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_cell_bus_port.sv
module tb_cell_bus_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  unit_addr_n = 5'b10000;
  logic        inhibit = 1'b0;
  logic        frame_sync_n = 1'b1;
  logic [31:0] bus_in = '0;
  logic [31:0] bus_out, bus_oe, rx_data;
  logic        tx_pending = 1'b0;
  logic [31:0] tx_word = '0;
  logic        tx_rd, rx_full, rx_we, ack_n;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  assign rx_full = full_r;
  logic full_r = 1'b0;

  always #5 clk = ~clk;

  cell_bus_port dut (
    .clk(clk), .rst_n(rst_n), .unit_addr_n(unit_addr_n), .inhibit(inhibit),
    .frame_sync_n(frame_sync_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .tx_pending(tx_pending), .tx_word(tx_word),
    .tx_rd(tx_rd), .rx_full(rx_full), .rx_we(rx_we), .rx_data(rx_data),
    .ack_n(ack_n)
  );

  typedef struct packed {
    bit       pend, inh, full, mc;
    bit [4:0] dest;
    bit       gv;
    bit [4:0] ga;
    bit       e_req, e_ack, e_tx, e_rx;
  } vec_t;

  localparam vec_t VECS[10] = '{
    '{1,0,0,0,5'd3, 1,5'd15, 1,0,0,0},  // R2 request, R6 no cell yet
    '{1,0,0,0,5'd15,0,5'd0,  0,0,1,1},  // R3 transmit, R4 no request
    '{0,0,0,0,5'd15,1,5'd3,  0,1,0,0},  // R7 ack, R6 idle frame
    '{0,0,0,1,5'd9, 1,5'd7,  0,0,0,1},  // R6 multicast accepted
    '{0,0,0,0,5'd9, 1,5'd7,  0,0,0,0},  // R8 no ack, R6 foreign dest
    '{0,0,1,0,5'd15,1,5'd2,  0,0,0,0},  // R9 full blocks write
    '{1,1,0,0,5'd15,1,5'd15, 0,0,0,1},  // R9 ack owed, R10 inhibited
    '{1,0,0,1,5'd15,1,5'd15, 1,1,0,1},  // R2 and R7 together, R8
    '{1,1,0,0,5'd4, 0,5'd0,  0,0,0,0},  // R10 granted but inhibited
    '{1,0,0,0,5'd15,0,5'd0,  1,0,0,0}   // R2 request again, R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input vec_t v);
    logic [4:0]  a;
    logic [31:0] mask;
    bit tx_ok, rx_ok;
    a = ~unit_addr_n;
    mask = 32'h3 << (2 * a[3:0]);
    tx_ok = 1'b1;
    rx_ok = 1'b1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      tx_pending = v.pend;
      inhibit = v.inh;
      full_r = v.full;
      frame_sync_n = (c != 0);
      tx_word = 32'hD000_0000 | c;
      if (c == 1) bus_in = {24'hC0FFEE, 2'b00, v.mc, v.dest};
      else if (c == 15) bus_in = {26'd0, v.gv, v.ga};
      else bus_in = 32'h1000_0000 | c;
      #2;
      if (c == 0) begin
        chk(bus_oe == (v.e_req ? mask : 32'h0) && bus_out == bus_oe,
            "R1/R2 request mask", bus_oe, v.e_req ? mask : 32'h0);
        chk(ack_n == !v.e_ack, "R7 ack_n in request cycle", {31'd0, ack_n},
            {31'd0, !v.e_ack});
      end else if (c <= 14) begin
        if (tx_rd != v.e_tx) tx_ok = 1'b0;
        if (v.e_tx && (bus_out != tx_word || bus_oe != '1)) tx_ok = 1'b0;
        if (!v.e_tx && bus_oe != '0) tx_ok = 1'b0;
        if (rx_we != v.e_rx) rx_ok = 1'b0;
        if (v.e_rx && rx_data != bus_in) rx_ok = 1'b0;
      end else begin
        chk(bus_oe == '0 && !tx_rd && !rx_we && ack_n, "R5 grant cycle quiet",
            bus_oe, 32'h0);
      end
    end
    chk(tx_ok, "R3 transmit words", {31'd0, tx_rd}, {31'd0, v.e_tx});
    chk(rx_ok, "R6 receive words", {31'd0, rx_we}, {31'd0, v.e_rx});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tx_pending = 1'b1;
    #2;
    chk(ack_n && bus_oe == '0 && !tx_rd && !rx_we, "R11 reset state", bus_oe, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(ack_n && bus_oe == '0 && !tx_rd && !rx_we, "R11 before first sync",
        bus_oe, 32'h0);
    foreach (VECS[i]) run_frame(VECS[i]);
    unit_addr_n = 5'b01010;  // R1: address 21 -> bits 11:10
    run_frame('{1,0,0,0,5'd15,0,5'd0, 1,0,0,0});
    unit_addr_n = 5'b11111;  // R1: address 0 -> bits 1:0
    run_frame('{1,0,0,0,5'd0,0,5'd0, 1,0,0,0});
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule